// File: doc/BRIEF.md
# Serial ADC Output Shifter

This block is the digital output stage of a serial sampling converter. It can also stand in for such a converter when a host interface is being verified. A parallel two's-complement sample enters through a valid/ready port and waits in a holding register. An active-low frame select and a serial clock then control the frame. The falling edge of the select captures the held sample and the format choice, enters hold mode, and starts driving the serial line. Each later falling edge of the serial clock presents the next bit of a 16-bit frame: zero padding first, then the sample MSB first, with trailing zero padding when the narrow format is selected.

The select and serial clock are sampled on the block's own clock, which must be well above the serial clock rate. The first zero, the release of the line when the select rises, and the entry into hold mode all follow the select pin within the same system clock cycle. The drive enable and the data value are separate outputs, so a testbench or pad wrapper can build the three-state line from them.

Back-pressure rules: `smp_ready` is high while no frame is open. It goes low on the clock edge that sees the select fall, and returns high on the edge after the select rises. A sample offered while ready is low is not taken and stays on the port. A sample taken on the same edge that opens a frame is kept for the next frame. The frame that opens on that edge uses the value held before it.

Top module: `adc_serial_shifter`

## Requirements
- R1: After reset, `sd_oe` and `hold` are 0 and `smp_ready` is 1.
- R2: A sample is stored when `smp_valid` and `smp_ready` are both 1 at a clock edge. `smp_ready` is 0 from the edge that sees the select low in a new frame until the edge after the select rises. While `smp_ready` is 0, offered samples are not stored, and a frame opened without a new load reuses the last stored sample.
- R3: In the same cycle that `sel_n` falls, `sd_oe` is 1, `sd_out` is 0 and `hold` is 1.
- R4: The frame content is fixed at the select fall: the stored sample and `fmt_narrow` are captured there, and changes to the input port afterwards do not alter the frame.
- R5: Each sampled falling edge of `sclk` advances one bit position. Falling edges 1 to 3 present 0, so the frame starts with four zeros.
- R6: With `fmt_narrow` = 0, falling edge k (4 to 15) presents sample bit 15-k, so all 12 bits go out MSB first.
- R7: With `fmt_narrow` = 1, falling edge k (4 to 13) presents sample bit 13-k, so bits 9..0 go out MSB first. Edges 14 and 15 present 0, and sample bits 11..10 are ignored.
- R8: `hold` stays 1 through the 13th falling edge. It goes to 0 on the first rising edge of `sclk` after the 13th falling edge.
- R9: On the 16th falling edge `sd_oe` goes to 0. Further falling edges leave it at 0 until the next select fall, because the edge count saturates.
- R10: When `sel_n` rises, `sd_oe` is 0 in that same cycle, `hold` is 0 after the next clock edge, and the frame ends. The next select fall starts a fresh frame from its first zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples select and serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 12 | Two's-complement sample |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample accepted when high with valid |
| fmt_narrow | input | 1 | 0: 12 data bits; 1: 10 data bits plus two zeros |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; bits advance on falling edges |
| sd_out | output | 1 | Serial data value |
| sd_oe | output | 1 | Serial line drive enable (0 = high impedance) |
| hold | output | 1 | 1 while the sample is held, 0 while tracking |

## Verification
A corrupted edge count shows as a shifted bit or a wrong enable on the very next serial falling edge. Every bit position of every frame is compared, so an off-by-one in either format shows within one frame. A wrong captured word or format flag shows at falling edge 4, the first data bit. A hold or enable flag that does not clear on an abort or at edge 16 shows one system cycle later on `hold` or `sd_oe`. Saturation faults only show in bursts longer than 16 edges, so such bursts are driven explicitly.

// File: rtl/adc_serial_shifter_pkg.sv
package adc_serial_shifter_pkg;
  localparam int unsigned DEF_SAMPLE_W  = 12;
  localparam int unsigned DEF_NARROW_W  = 10;
  localparam int unsigned DEF_LEAD_ZERO = 4;
  localparam int unsigned DEF_HOLD_EDGE = 13;

  typedef enum logic {
    FMT_WIDE   = 1'b0,
    FMT_NARROW = 1'b1
  } fmt_e;
endpackage

// File: rtl/ass_edge_sense.sv
module ass_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  output logic sel_fall,
  output logic sclk_fall,
  output logic sclk_rise,
  output logic sclk_prev
);
  logic sel_q;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      sel_q  <= sel_n;
      sclk_q <= sclk;
    end
  end

  assign sel_fall  = sel_q & ~sel_n;
  assign sclk_fall = sclk_q & ~sclk;
  assign sclk_rise = ~sclk_q & sclk;
  assign sclk_prev = sclk_q;
endmodule

// File: rtl/ass_word_build.sv
module ass_word_build
  import adc_serial_shifter_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
  parameter int unsigned NARROW_W  = DEF_NARROW_W,
  parameter int unsigned LEAD_ZERO = DEF_LEAD_ZERO,
  localparam int unsigned FRAME_W  = LEAD_ZERO + SAMPLE_W,
  localparam int unsigned PAD_W    = SAMPLE_W - NARROW_W
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  fmt_e                fmt,
  output logic [FRAME_W-1:0]  word
);
  logic [SAMPLE_W-1:0] body_narrow;

  generate
    if (PAD_W > 0) begin : g_pad
      assign body_narrow = {sample[NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign body_narrow = sample;
    end
  endgenerate

  always_comb begin
    word = '0;
    if (fmt == FMT_NARROW) word[SAMPLE_W-1:0] = body_narrow;
    else                   word[SAMPLE_W-1:0] = sample;
  end
endmodule

// File: rtl/ass_edge_counter.sv
module ass_edge_counter #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  count <= '0;
    else if (clear)                              count <= '0;
    else if (step && count < CNT_W'(LIMIT))      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/adc_serial_shifter.sv
module adc_serial_shifter
  import adc_serial_shifter_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = DEF_SAMPLE_W,
  parameter int unsigned NARROW_W   = DEF_NARROW_W,
  parameter int unsigned LEAD_ZERO  = DEF_LEAD_ZERO,
  parameter int unsigned HOLD_EDGE  = DEF_HOLD_EDGE,
  localparam int unsigned FRAME_W   = LEAD_ZERO + SAMPLE_W,
  localparam int unsigned CNT_W     = $clog2(FRAME_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic                fmt_narrow,
  input  logic                sel_n,
  input  logic                sclk,
  output logic                sd_out,
  output logic                sd_oe,
  output logic                hold
);
  logic                sel_fall, sclk_fall, sclk_rise, sclk_prev;
  logic [SAMPLE_W-1:0] pend_q;
  logic [FRAME_W-1:0]  word_next, word_q;
  logic                active_q, hold_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                cnt_step;
  logic                in_frame;
  logic                bit_val;
  fmt_e                fmt_in;

  ass_edge_sense u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .sclk      (sclk),
    .sel_fall  (sel_fall),
    .sclk_fall (sclk_fall),
    .sclk_rise (sclk_rise),
    .sclk_prev (sclk_prev)
  );

  assign fmt_in = fmt_narrow ? FMT_NARROW : FMT_WIDE;

  ass_word_build #(
    .SAMPLE_W  (SAMPLE_W),
    .NARROW_W  (NARROW_W),
    .LEAD_ZERO (LEAD_ZERO)
  ) u_build (
    .sample (pend_q),
    .fmt    (fmt_in),
    .word   (word_next)
  );

  assign cnt_step = active_q & ~sel_n & sclk_fall;

  ass_edge_counter #(.LIMIT(FRAME_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (sel_fall),
    .step  (cnt_step),
    .count (cnt_q)
  );

  assign smp_ready = ~active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pend_q <= '0;
    else if (smp_valid && smp_ready)  pend_q <= smp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      active_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (sel_n) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (sel_fall) begin
      word_q   <= word_next;
      active_q <= 1'b1;
      hold_q   <= 1'b1;
    end else if (active_q && sclk_rise && cnt_q >= CNT_W'(HOLD_EDGE)) begin
      hold_q   <= 1'b0;
    end
  end

  assign in_frame = active_q & (cnt_q < CNT_W'(FRAME_W));

  always_comb begin
    bit_val = 1'b0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (cnt_q == CNT_W'(i)) bit_val = word_q[FRAME_W-1-i];
    end
  end

  assign sd_oe  = ~sel_n & (sel_fall | in_frame);
  assign sd_out = sd_oe & ~sel_fall & bit_val;
  assign hold   = hold_q | sel_fall;
endmodule

// File: rtl/adc_serial_shifter_chk.sv
module adc_serial_shifter_chk #(
  parameter int unsigned FRAME_W   = 16,
  parameter int unsigned HOLD_EDGE = 13,
  parameter int unsigned CNT_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             sclk,
  input logic             sd_oe,
  input logic             sd_out,
  input logic             hold,
  input logic             sel_fall,
  input logic             sclk_prev,
  input logic             active_q,
  input logic             hold_q,
  input logic [CNT_W-1:0] cnt_q
);
  p_release_on_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !sd_oe);

  p_first_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |-> (sd_oe && !sd_out && hold));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));

  p_quiet_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == CNT_W'(FRAME_W) && !sel_fall) |-> !sd_oe);

  p_track_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !hold_q && !sel_n) |=> !hold_q);

  p_hold_until_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && hold_q && !sel_n && cnt_q < CNT_W'(HOLD_EDGE)) |=> hold_q);

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sel_n && sclk_prev && !sclk && cnt_q < CNT_W'(FRAME_W))
      |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
endmodule

bind adc_serial_shifter adc_serial_shifter_chk #(
  .FRAME_W   (FRAME_W),
  .HOLD_EDGE (HOLD_EDGE),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .sclk      (sclk),
  .sd_oe     (sd_oe),
  .sd_out    (sd_out),
  .hold      (hold),
  .sel_fall  (sel_fall),
  .sclk_prev (sclk_prev),
  .active_q  (active_q),
  .hold_q    (hold_q),
  .cnt_q     (cnt_q)
);

// File: tb/adc_serial_shifter_bench.sv
`timescale 1ns/1ps
module adc_serial_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic        fmt_narrow = 1'b0;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sd_out, sd_oe, hold;

  int n_chk = 0;
  int n_fail = 0;
  int held = 0;

  always #2.5 clk = ~clk;

  adc_serial_shifter u_adc_serial_shifter (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .fmt_narrow(fmt_narrow), .sel_n(sel_n), .sclk(sclk),
    .sd_out(sd_out), .sd_oe(sd_oe), .hold(hold)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bit(input int s, input bit nar, input int k);
    if (k < 4) return 0;
    if (nar) return (k < 14) ? ((s >> (13 - k)) & 1) : 0;
    return (s >> (15 - k)) & 1;
  endfunction

  function automatic string bit_req(input bit nar, input int k);
    if (k < 4) return "R5";
    return nar ? "R7" : "R6";
  endfunction

  task automatic run_frame(input bit nar, input int nfalls, input int abort_at,
                           input bit do_load, input int s_load);
    if (do_load) begin
      @(negedge clk); smp_data = 12'(s_load); smp_valid = 1'b1;
      #1 chk(smp_ready == 1'b1, "R2", int'(smp_ready), 1);
      @(negedge clk); smp_valid = 1'b0;
      held = s_load;
    end
    @(negedge clk); sel_n = 1'b0; fmt_narrow = nar;
    #1;
    chk(sd_oe == 1'b1, "R3", int'(sd_oe), 1);
    chk(sd_out == 1'b0, "R3", int'(sd_out), 0);
    chk(hold == 1'b1, "R3", int'(hold), 1);
    @(posedge clk); #1;
    chk(smp_ready == 1'b0, "R2", int'(smp_ready), 0);
    @(negedge clk);
    smp_data = ~12'(held); smp_valid = 1'b1; fmt_narrow = ~nar;  // R4: port changes after capture
    for (int k = 1; k <= nfalls; k++) begin
      @(negedge clk); sclk = 1'b0;
      @(posedge clk); #1;
      if (k < 16) begin
        chk(sd_oe == 1'b1, "R5", int'(sd_oe), 1);
        chk(int'(sd_out) == exp_bit(held, nar, k), bit_req(nar, k),
            int'(sd_out), exp_bit(held, nar, k));
      end else begin
        chk(sd_oe == 1'b0, "R9", int'(sd_oe), 0);
      end
      chk(int'(hold) == int'(k <= 13), "R8", int'(hold), int'(k <= 13));
      if (k == abort_at) begin
        @(negedge clk); sel_n = 1'b1; sclk = 1'b1; smp_valid = 1'b0;
        #1 chk(sd_oe == 1'b0, "R10", int'(sd_oe), 0);
        @(posedge clk); #1 chk(hold == 1'b0, "R10", int'(hold), 0);
        break;
      end
      @(negedge clk); sclk = 1'b1;
      @(posedge clk); #1;
      chk(int'(hold) == int'(k < 13), "R8", int'(hold), int'(k < 13));
      if (k >= 16) chk(sd_oe == 1'b0, "R9", int'(sd_oe), 0);
    end
    @(negedge clk); sel_n = 1'b1; sclk = 1'b1; smp_valid = 1'b0;
    #1 chk(sd_oe == 1'b0, "R10", int'(sd_oe), 0);
    @(posedge clk); @(posedge clk); #1;
    chk(smp_ready == 1'b1, "R2", int'(smp_ready), 1);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(sd_oe == 1'b0, "R1", int'(sd_oe), 0);
    chk(hold == 1'b0, "R1", int'(hold), 0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(smp_ready == 1'b1, "R1", int'(smp_ready), 1);

    for (int i = 0; i < 48; i++) run_frame(1'b0, 16, 0, 1'b1, (i * 683 + 5) % 4096);
    for (int i = 0; i < 48; i++)
      run_frame(1'b1, 16, 0, 1'b1, ((i * 331 + 1) % 1024) | ((i % 4) << 10));
    run_frame(1'b0, 16, 0, 1'b1, 12'h800);
    run_frame(1'b0, 16, 0, 1'b1, 12'h7FF);
    run_frame(1'b1, 16, 0, 1'b1, 12'hFFF);
    run_frame(1'b1, 16, 0, 1'b1, 12'h200);
    // R2/R4: no new load, previous sample reused in both formats
    run_frame(1'b0, 16, 0, 1'b0, 0);
    run_frame(1'b1, 16, 0, 1'b0, 0);
    // R9: long bursts
    run_frame(1'b0, 20, 0, 1'b1, 12'hA5C);
    run_frame(1'b1, 18, 0, 1'b1, 12'h3C3);
    // R10: aborts then clean frames
    run_frame(1'b0, 16, 5, 1'b1, 12'h9E1);
    run_frame(1'b0, 16, 0, 1'b1, 12'h1B7);
    run_frame(1'b1, 16, 14, 1'b1, 12'h2D4);
    run_frame(1'b1, 16, 0, 1'b0, 0);
    run_frame(1'b0, 16, 1, 1'b1, 12'hFFF);
    run_frame(1'b0, 16, 0, 1'b0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule